// File: doc/BRIEF.md
# Hardware Cursor Clip and Position Unit

This block turns a requested cursor placement into the values a display pipeline needs to draw a hardware cursor. Its inputs are a signed screen position, a requested cursor width and height, and the size of the active display area. From these it works out how much of the cursor is visible, where on the screen the visible part starts, and how far into the cursor bitmap the first visible pixel lies. It clips against all four screen edges. In interlaced modes it halves the vertical extent and the vertical position.

A request that passes the size check is held in shadow registers. The packed position and size words reach the live registers, and the cursor is enabled, only on the next frame-done pulse. Updates therefore never tear a frame. A request that leaves nothing visible, or that arrives with no cursor image, turns the cursor off at once. A request that changes the visible size also turns the cursor off at once, and the commit waits until the loader reports that the new image is in place.

The unit also converts loader pixel words from ARGB byte order to the storage order, in which red and blue trade places.

Top module: `cursor_clip_top`

## Requirements
- R1: A request whose width or height exceeds 64, or whose width and height both exceed 32, is rejected. `reqRejected` is 1 from the cycle after the request until the next request. The rejected request changes none of `cursorEnable`, `updatePending`, the live words or the bitmap offsets.
- R2: For a negative X position, the bitmap X offset equals the negated position, the visible width is the requested width minus that offset (never below 0), and the screen X is 0. A negative Y position is handled the same way on the vertical axis.
- R3: When position plus requested size exceeds the active width (or height), the visible extent is the active size minus the position, clamped at 0, and the screen coordinate is the position itself.
- R4: With `interlaced` high, the visible height and the screen Y are each shifted right by one bit after clipping.
- R5: When a request leaves a visible width or height of 0, or `imagePresent` is low, `cursorEnable` and `updatePending` are both 0 on the cycle after the request, and a later frame-done commits nothing.
- R6: The position word holds screen Y in bits 31:16 and screen X in bits 15:0. The size word holds visible height in bits 31:16 and visible width in bits 15:0.
- R7: An accepted request sets `updatePending`. The live words are copied from the shadow registers and `cursorEnable` is set only on the cycle after a `frameDone` pulse while an update is pending, and that same commit clears `updatePending`.
- R8: An accepted request whose size word differs from the last accepted one clears `cursorEnable` on the next cycle. The commit then waits for an `imageLoaded` pulse, and frame-done pulses before that pulse are ignored.
- R9: `pixelOut` is `pixelIn` with bits 23:16 and bits 7:0 exchanged. Bits 31:24 and 15:8 pass through unchanged, and the output is combinational.
- R10: When a request and a frame-done pulse fall in the same cycle, the request is taken and the commit waits for a later frame-done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cursorReq | input | 1 | One-cycle pulse: evaluate a new placement |
| posX | input | 16 | Signed cursor X position |
| posY | input | 16 | Signed cursor Y position |
| sizeW | input | 7 | Requested cursor width |
| sizeH | input | 7 | Requested cursor height |
| activeW | input | 16 | Active display width |
| activeH | input | 16 | Active display height |
| interlaced | input | 1 | Interlaced output mode |
| imagePresent | input | 1 | A cursor image is attached |
| imageLoaded | input | 1 | Pulse: the loader has finished writing the new image |
| frameDone | input | 1 | Pulse: the current frame has finished |
| pixelIn | input | 32 | ARGB pixel word from the loader |
| pixelOut | output | 32 | Pixel word in storage byte order |
| reqRejected | output | 1 | The last request exceeded the size limits |
| updatePending | output | 1 | Shadow values are waiting for frame-done |
| cursorEnable | output | 1 | Live cursor enable |
| livePos | output | 32 | Live packed position word |
| liveSize | output | 32 | Live packed size word |
| bitmapOffX | output | 16 | Bitmap X offset of the last accepted request |
| bitmapOffY | output | 16 | Bitmap Y offset of the last accepted request |

## Verification
The assertions watch four properties on every cycle. An oversize request raises the reject flag and leaves the enable and pending state untouched. The live words change only right after a frame-done pulse. The enable rises only at a commit. A live size never exceeds the dimension limit. The clipping arithmetic on each edge, the interlace halving and the byte swap depend on particular operand values, so only the bench's scenarios show them. The same holds for the commit held back by a size change until the image is loaded, and for a request that collides with frame-done.

// File: rtl/cursor_clip_pkg.sv
package cursor_clip_pkg;
  typedef struct packed {
    logic loadShadow;
    logic commit;
  } dpStrobes_t;
endpackage

// File: rtl/cursor_clip_axis.sv
module cursor_clip_axis #(
  parameter int CoordW = 16,
  parameter int SizeW  = 7
) (
  input  logic [CoordW-1:0] pos,
  input  logic [SizeW-1:0]  size,
  input  logic [CoordW-1:0] active,
  input  logic              halve,
  output logic [CoordW-1:0] scr,
  output logic [SizeW-1:0]  vis,
  output logic [CoordW-1:0] off
);
  localparam int EW = CoordW + 2;

  logic signed [EW-1:0] posE, sizeE, actE, visE, scrE, offE;

  always_comb begin
    posE  = $signed({{2{pos[CoordW-1]}}, pos});
    sizeE = $signed({{(EW-SizeW){1'b0}}, size});
    actE  = $signed({2'b00, active});
    if (posE < 0) begin
      offE = -posE;
      visE = sizeE + posE;
      scrE = '0;
    end else if (posE + sizeE > actE) begin
      offE = '0;
      visE = actE - posE;
      scrE = posE;
    end else begin
      offE = '0;
      visE = sizeE;
      scrE = posE;
    end
    if (visE < 0) visE = '0;
    if (halve) begin
      visE = visE >>> 1;
      scrE = scrE >>> 1;
    end
    vis = visE[SizeW-1:0];
    scr = scrE[CoordW-1:0];
    off = offE[CoordW-1:0];
  end
endmodule

// File: rtl/cursor_clip_dp.sv
module cursor_clip_dp
  import cursor_clip_pkg::*;
#(
  parameter int CoordW  = 16,
  parameter int SizeW   = 7,
  parameter int MaxDim  = 64,
  parameter int HalfDim = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobes_t            st,
  input  logic [CoordW-1:0]     posX,
  input  logic [CoordW-1:0]     posY,
  input  logic [SizeW-1:0]      sizeW,
  input  logic [SizeW-1:0]      sizeH,
  input  logic [CoordW-1:0]     activeW,
  input  logic [CoordW-1:0]     activeH,
  input  logic                  interlaced,
  input  logic [31:0]           pixelIn,
  output logic [31:0]           pixelOut,
  output logic                  oversize,
  output logic                  visZero,
  output logic                  sizeDiffers,
  output logic [2*CoordW-1:0]   livePos,
  output logic [2*CoordW-1:0]   liveSize,
  output logic [CoordW-1:0]     bitmapOffX,
  output logic [CoordW-1:0]     bitmapOffY
);
  localparam int WordW = 2 * CoordW;

  logic [CoordW-1:0] scrX, scrY, offX, offY;
  logic [SizeW-1:0]  visW, visH;
  logic [WordW-1:0]  newPos, newSize, shadowPos, shadowSize;

  cursor_clip_axis #(.CoordW(CoordW), .SizeW(SizeW)) axisX_i (
    .pos(posX), .size(sizeW), .active(activeW), .halve(1'b0),
    .scr(scrX), .vis(visW), .off(offX));

  cursor_clip_axis #(.CoordW(CoordW), .SizeW(SizeW)) axisY_i (
    .pos(posY), .size(sizeH), .active(activeH), .halve(interlaced),
    .scr(scrY), .vis(visH), .off(offY));

  always_comb begin
    oversize = (sizeW > SizeW'(MaxDim)) || (sizeH > SizeW'(MaxDim)) ||
               ((sizeW > SizeW'(HalfDim)) && (sizeH > SizeW'(HalfDim)));
    visZero     = (visW == '0) || (visH == '0);
    newPos      = {scrY, scrX};
    newSize     = {CoordW'(visH), CoordW'(visW)};
    sizeDiffers = (newSize != shadowSize);
    pixelOut    = {pixelIn[31:24], pixelIn[7:0], pixelIn[15:8], pixelIn[23:16]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowPos  <= '0;
      shadowSize <= '0;
      bitmapOffX <= '0;
      bitmapOffY <= '0;
      livePos    <= '0;
      liveSize   <= '0;
    end else begin
      if (st.loadShadow) begin
        shadowPos  <= newPos;
        shadowSize <= newSize;
        bitmapOffX <= offX;
        bitmapOffY <= offY;
      end
      if (st.commit) begin
        livePos  <= shadowPos;
        liveSize <= shadowSize;
      end
    end
  end
endmodule

// File: rtl/cursor_clip_ctrl.sv
module cursor_clip_ctrl
  import cursor_clip_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cursorReq,
  input  logic       frameDone,
  input  logic       imagePresent,
  input  logic       imageLoaded,
  input  logic       oversize,
  input  logic       visZero,
  input  logic       sizeDiffers,
  output dpStrobes_t st,
  output logic       reqRejected,
  output logic       updatePending,
  output logic       cursorEnable
);
  logic awaitLoad;

  always_comb begin
    st.loadShadow = cursorReq && !oversize && !visZero && imagePresent;
    st.commit     = !cursorReq && frameDone && updatePending && !awaitLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqRejected   <= 1'b0;
      updatePending <= 1'b0;
      cursorEnable  <= 1'b0;
      awaitLoad     <= 1'b0;
    end else begin
      if (imageLoaded) awaitLoad <= 1'b0;
      if (cursorReq) begin
        reqRejected <= oversize;
        if (!oversize) begin
          if (visZero || !imagePresent) begin
            cursorEnable  <= 1'b0;
            updatePending <= 1'b0;
            awaitLoad     <= 1'b0;
          end else begin
            updatePending <= 1'b1;
            if (sizeDiffers) begin
              cursorEnable <= 1'b0;
              awaitLoad    <= 1'b1;
            end
          end
        end
      end else if (st.commit) begin
        cursorEnable  <= 1'b1;
        updatePending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cursor_clip_top.sv
module cursor_clip_top
  import cursor_clip_pkg::*;
#(
  parameter int CoordW  = 16,
  parameter int SizeW   = 7,
  parameter int MaxDim  = 64,
  parameter int HalfDim = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cursorReq,
  input  logic [CoordW-1:0]   posX,
  input  logic [CoordW-1:0]   posY,
  input  logic [SizeW-1:0]    sizeW,
  input  logic [SizeW-1:0]    sizeH,
  input  logic [CoordW-1:0]   activeW,
  input  logic [CoordW-1:0]   activeH,
  input  logic                interlaced,
  input  logic                imagePresent,
  input  logic                imageLoaded,
  input  logic                frameDone,
  input  logic [31:0]         pixelIn,
  output logic [31:0]         pixelOut,
  output logic                reqRejected,
  output logic                updatePending,
  output logic                cursorEnable,
  output logic [2*CoordW-1:0] livePos,
  output logic [2*CoordW-1:0] liveSize,
  output logic [CoordW-1:0]   bitmapOffX,
  output logic [CoordW-1:0]   bitmapOffY
);
  dpStrobes_t st;
  logic oversize, visZero, sizeDiffers;

  cursor_clip_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cursorReq(cursorReq), .frameDone(frameDone),
    .imagePresent(imagePresent), .imageLoaded(imageLoaded),
    .oversize(oversize), .visZero(visZero), .sizeDiffers(sizeDiffers),
    .st(st), .reqRejected(reqRejected), .updatePending(updatePending),
    .cursorEnable(cursorEnable));

  cursor_clip_dp #(.CoordW(CoordW), .SizeW(SizeW), .MaxDim(MaxDim), .HalfDim(HalfDim)) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .posX(posX), .posY(posY),
    .sizeW(sizeW), .sizeH(sizeH), .activeW(activeW), .activeH(activeH),
    .interlaced(interlaced), .pixelIn(pixelIn), .pixelOut(pixelOut),
    .oversize(oversize), .visZero(visZero), .sizeDiffers(sizeDiffers),
    .livePos(livePos), .liveSize(liveSize),
    .bitmapOffX(bitmapOffX), .bitmapOffY(bitmapOffY));
endmodule

// File: rtl/cursor_clip_chk.sv
module cursor_clip_chk #(
  parameter int CoordW  = 16,
  parameter int SizeW   = 7,
  parameter int MaxDim  = 64,
  parameter int HalfDim = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                cursorReq,
  input logic [SizeW-1:0]    sizeW,
  input logic [SizeW-1:0]    sizeH,
  input logic                frameDone,
  input logic                reqRejected,
  input logic                updatePending,
  input logic                cursorEnable,
  input logic [2*CoordW-1:0] livePos,
  input logic [2*CoordW-1:0] liveSize
);
  logic tooBig;
  assign tooBig = (sizeW > SizeW'(MaxDim)) || (sizeH > SizeW'(MaxDim)) ||
                  ((sizeW > SizeW'(HalfDim)) && (sizeH > SizeW'(HalfDim)));

  assert_reject_flag_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cursorReq && tooBig) |=> reqRejected);

  assert_reject_no_effect_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cursorReq && tooBig) |=> ($stable(cursorEnable) && $stable(updatePending)));

  assert_live_on_commit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(livePos) || !$stable(liveSize)) |-> $past(frameDone));

  assert_enable_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cursorEnable) |-> ($past(frameDone) && !updatePending));

  assert_size_limit_R1: assert property (@(posedge clk) disable iff (!rstN)
    cursorEnable |-> (liveSize[CoordW-1:0] <= CoordW'(MaxDim) &&
                      liveSize[2*CoordW-1:CoordW] <= CoordW'(MaxDim)));
endmodule

bind cursor_clip_top cursor_clip_chk #(.CoordW(CoordW), .SizeW(SizeW),
  .MaxDim(MaxDim), .HalfDim(HalfDim)) chk_i (
  .clk(clk), .rstN(rstN), .cursorReq(cursorReq), .sizeW(sizeW), .sizeH(sizeH),
  .frameDone(frameDone), .reqRejected(reqRejected), .updatePending(updatePending),
  .cursorEnable(cursorEnable), .livePos(livePos), .liveSize(liveSize));

// File: tb/cursor_clip_tb.sv
`timescale 1ns/1ps
module cursor_clip_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cursorReq = 0, interlaced = 0, imagePresent = 1, imageLoaded = 0, frameDone = 0;
  logic [15:0] posX = 0, posY = 0, activeW = 16'd800, activeH = 16'd600;
  logic [6:0] sizeW = 0, sizeH = 0;
  logic [31:0] pixelIn = 0, pixelOut, livePos, liveSize;
  logic reqRejected, updatePending, cursorEnable;
  logic [15:0] bitmapOffX, bitmapOffY;

  int nTests = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  cursor_clip_top dut_i (
    .clk(clk), .rstN(rstN), .cursorReq(cursorReq), .posX(posX), .posY(posY),
    .sizeW(sizeW), .sizeH(sizeH), .activeW(activeW), .activeH(activeH),
    .interlaced(interlaced), .imagePresent(imagePresent), .imageLoaded(imageLoaded),
    .frameDone(frameDone), .pixelIn(pixelIn), .pixelOut(pixelOut),
    .reqRejected(reqRejected), .updatePending(updatePending), .cursorEnable(cursorEnable),
    .livePos(livePos), .liveSize(liveSize), .bitmapOffX(bitmapOffX), .bitmapOffY(bitmapOffY));

  typedef struct packed {
    logic signed [15:0] x;
    logic signed [15:0] y;
    logic [6:0]  w;
    logic [6:0]  h;
    logic        il;
    logic        rej;
    logic        en;
    logic [31:0] pos;
    logic [31:0] size;
    logic [15:0] offX;
    logic [15:0] offY;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'sd100, 16'sd50,  7'd64, 7'd32, 1'b0, 1'b0, 1'b1, 32'h0032_0064, 32'h0020_0040, 16'd0,  16'd0},
    '{-16'sd10, 16'sd20,  7'd32, 7'd64, 1'b0, 1'b0, 1'b1, 32'h0014_0000, 32'h0040_0016, 16'd10, 16'd0},
    '{16'sd790, 16'sd595, 7'd32, 7'd32, 1'b0, 1'b0, 1'b1, 32'h0253_0316, 32'h0005_000A, 16'd0,  16'd0},
    '{16'sd0,   16'sd0,   7'd33, 7'd33, 1'b0, 1'b1, 1'b1, 32'h0253_0316, 32'h0005_000A, 16'd0,  16'd0},
    '{16'sd10,  -16'sd5,  7'd16, 7'd16, 1'b0, 1'b0, 1'b1, 32'h0000_000A, 32'h000B_0010, 16'd0,  16'd5},
    '{16'sd100, 16'sd200, 7'd32, 7'd64, 1'b1, 1'b0, 1'b1, 32'h0064_0064, 32'h0020_0020, 16'd0,  16'd0},
    '{16'sd0,   16'sd0,   7'd65, 7'd8,  1'b0, 1'b1, 1'b1, 32'h0064_0064, 32'h0020_0020, 16'd0,  16'd0},
    '{-16'sd40, 16'sd0,   7'd32, 7'd16, 1'b0, 1'b0, 1'b0, 32'h0064_0064, 32'h0020_0020, 16'd0,  16'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReq(input logic [15:0] x, input logic [15:0] y,
                       input logic [6:0] w, input logic [6:0] h, input logic il);
    @(negedge clk);
    posX = x; posY = y; sizeW = w; sizeH = h; interlaced = il; cursorReq = 1;
    @(negedge clk);
    cursorReq = 0;
  endtask

  task automatic pulseLoad();
    imageLoaded = 1;
    @(negedge clk);
    imageLoaded = 0;
  endtask

  task automatic pulseFrame();
    frameDone = 1;
    @(negedge clk);
    frameDone = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state (R7)
    check("R7 reset enable", {31'b0, cursorEnable}, 32'd0);
    check("R7 reset pending", {31'b0, updatePending}, 32'd0);
    check("R1 reset reject", {31'b0, reqRejected}, 32'd0);
    check("R6 reset pos", livePos, 32'd0);

    // table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      doReq(VECS[i].x, VECS[i].y, VECS[i].w, VECS[i].h, VECS[i].il);
      check($sformatf("R1 reject row %0d", i), {31'b0, reqRejected}, {31'b0, VECS[i].rej});
      pulseLoad();
      pulseFrame();
      check($sformatf("R5 enable row %0d", i), {31'b0, cursorEnable}, {31'b0, VECS[i].en});
      check($sformatf("R6 pos row %0d", i), livePos, VECS[i].pos);
      check($sformatf("R3 size row %0d", i), liveSize, VECS[i].size);
      check($sformatf("R2 offX row %0d", i), {16'b0, bitmapOffX}, {16'b0, VECS[i].offX});
      check($sformatf("R2 offY row %0d", i), {16'b0, bitmapOffY}, {16'b0, VECS[i].offY});
    end

    // R7: commit held until frame-done
    doReq(16'd50, 16'd60, 7'd16, 7'd16, 1'b0);
    pulseLoad();
    pulseFrame();
    check("R7 first commit", livePos, 32'h003C_0032);
    doReq(16'd70, 16'd80, 7'd16, 7'd16, 1'b0);
    check("R7 pending set", {31'b0, updatePending}, 32'd1);
    check("R7 enable kept, same size", {31'b0, cursorEnable}, 32'd1);
    check("R7 live pos held", livePos, 32'h003C_0032);
    pulseFrame();
    check("R7 live pos committed", livePos, 32'h0050_0046);
    check("R7 pending cleared", {31'b0, updatePending}, 32'd0);

    // R8: size change disables and waits for load
    doReq(16'd70, 16'd80, 7'd8, 7'd8, 1'b0);
    check("R8 enable cleared", {31'b0, cursorEnable}, 32'd0);
    pulseFrame();
    check("R8 no commit before load", liveSize, 32'h0010_0010);
    check("R8 still disabled", {31'b0, cursorEnable}, 32'd0);
    pulseLoad();
    pulseFrame();
    check("R8 commit after load", liveSize, 32'h0008_0008);
    check("R8 enabled", {31'b0, cursorEnable}, 32'd1);

    // R10: request collides with frame-done
    @(negedge clk);
    posX = 16'd90; posY = 16'd80; sizeW = 7'd8; sizeH = 7'd8; interlaced = 0;
    cursorReq = 1; frameDone = 1;
    @(negedge clk);
    cursorReq = 0; frameDone = 0;
    check("R10 pending after collision", {31'b0, updatePending}, 32'd1);
    check("R10 live pos unchanged", livePos, 32'h0050_0046);
    pulseFrame();
    check("R10 commit on later frame", livePos, 32'h0050_005A);

    // R5: no image present
    imagePresent = 0;
    doReq(16'd10, 16'd10, 7'd8, 7'd8, 1'b0);
    check("R5 no image disables", {31'b0, cursorEnable}, 32'd0);
    check("R5 no image pending", {31'b0, updatePending}, 32'd0);
    imagePresent = 1;

    // R4: interlaced height 1 halves to zero
    doReq(16'd10, 16'd10, 7'd8, 7'd8, 1'b0);
    pulseLoad();
    pulseFrame();
    doReq(16'd100, 16'd100, 7'd8, 7'd1, 1'b1);
    check("R4 halved height zero disables", {31'b0, cursorEnable}, 32'd0);

    // R9: pixel byte swap
    pixelIn = 32'h1122_3344;
    #1;
    check("R9 swap a", pixelOut, 32'h1144_3322);
    pixelIn = 32'hFF00_80A5;
    #1;
    check("R9 swap b", pixelOut, 32'hFFA5_8000);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule